// File: doc/BRIEF.md
# Greedy Spare Line Allocator

This block decides which rows and columns of a small defective memory block get swapped out for spares. A test engine writes the fault bitmap one row per cycle: a 1 bit marks a bad cell. Then it pulses `start`. The allocator first makes one pass to tally the bad cells on every row and every column. It then takes one decision per cycle. Each decision retires the line that currently carries the most faults and gives it a spare of the same orientation. The faults that line held are removed from the tallies of the lines that cross it.

When allocation ends, the block reports several results and holds them until the next `start`:
- whether the block is now fault-free,
- the retired rows and the retired columns, each list in the order the lines were assigned,
- for rows and for columns, a table that maps each logical line to the physical line that serves it.

The spare lines are part of the physical array. Of `ROWS` physical rows, `ROWS-SPARE_R` are visible logically. Of `COLS` physical columns, `COLS-SPARE_C` are visible logically.

Top module: `spare_line_alloc`

## Requirements
- R1: While reset is high, and after it, `busy`, `done` and `repair_ok` are 0 and both list counts are 0.
- R2: When `busy` is low, a high `ld_en` writes `ld_bits` into bitmap row `ld_row`; bit c of `ld_bits` marks cell (row, c) as faulty. While `busy` is high, `ld_en` is ignored.
- R3: A `start` taken while not busy raises `busy` on the next cycle. `done` becomes 1 exactly ROWS+k+1 rising edges after the edge that took `start`, where k is the number of spares assigned.
- R4: Each decision retires the line, row or column, with the largest current fault count.
- R5: If a row and a column tie for the largest count, the row is retired. Among equal rows, or among equal columns, the lowest index wins.
- R6: If no spare of the preferred orientation remains, the largest line of the other orientation is retired instead. At most SPARE_R rows and SPARE_C columns are ever retired.
- R7: Allocation stops as soon as all counts are zero, leaving unused spares. Both lists then hold only the lines actually retired.
- R8: Retiring a line removes its faults from the counts of every crossing line, so later decisions see only the faults still uncovered.
- R9: `repair_ok` is 1 with `done` only if no uncovered fault remains. Otherwise it is 0.
- R10: Entry i of `row_map` (bits i*RW+:RW) holds the i-th physical row, counted from 0, that is not retired. `col_map` is built the same way for columns.
- R11: List entry j sits at bits j*W+:W, in assignment order, and unused entries are 0. `done`, the lists, the maps and `repair_ok` hold their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one bitmap row |
| ld_row | input | $clog2(ROWS) | Row index to write |
| ld_bits | input | COLS | Fault bits of that row |
| start | input | 1 | Begin counting and allocation |
| busy | output | 1 | Allocation in progress |
| done | output | 1 | Results valid |
| repair_ok | output | 1 | Every fault covered by a spare |
| row_num | output | $clog2(SPARE_R+1) | Number of retired rows |
| row_list | output | SPARE_R*$clog2(ROWS) | Retired row indices |
| col_num | output | $clog2(SPARE_C+1) | Number of retired columns |
| col_list | output | SPARE_C*$clog2(COLS) | Retired column indices |
| row_map | output | (ROWS-SPARE_R)*$clog2(ROWS) | Logical to physical row table |
| col_map | output | (COLS-SPARE_C)*$clog2(COLS) | Logical to physical column table |

## Verification
The hold check assumes `start` stays low while results are on display. The bench therefore pulses `start` for exactly one cycle and only when the block is idle or done. Row indices on `ld_row` are assumed to lie below ROWS, and the stimulus writes only rows 0 to 7. The one load issued while busy is deliberate. It is followed by a rerun on the untouched bitmap, which exposes any write that should have been ignored.

// File: rtl/spare_alloc_pkg.sv
package spare_alloc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COUNT  = 2'd1,
    ST_SELECT = 2'd2,
    ST_DONE   = 2'd3
  } alloc_state_e;
endpackage

// File: rtl/line_peak.sv
// Finds the largest count; strict compare keeps the lowest index on ties.
module line_peak #(
  parameter int N  = 8,
  parameter int W  = 4,
  parameter int IW = 3
) (
  input  logic [N*W-1:0] cnt_flat,
  output logic [W-1:0]   peak,
  output logic [IW-1:0]  peak_idx
);
  always_comb begin
    peak     = '0;
    peak_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (cnt_flat[i*W +: W] > peak) begin
        peak     = cnt_flat[i*W +: W];
        peak_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/line_remap.sv
// Lists the surviving physical lines in ascending order.
module line_remap #(
  parameter int N  = 8,
  parameter int L  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]    excl,
  output logic [L*IW-1:0] map_flat
);
  always_comb begin
    int k;
    k        = 0;
    map_flat = '0;
    for (int p = 0; p < N; p++) begin
      if (!excl[p] && k < L) begin
        map_flat[k*IW +: IW] = IW'(p);
        k++;
      end
    end
  end
endmodule

// File: rtl/spare_line_alloc.sv
module spare_line_alloc
  import spare_alloc_pkg::*;
#(
  parameter int ROWS    = 8,
  parameter int COLS    = 8,
  parameter int SPARE_R = 2,
  parameter int SPARE_C = 2
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     ld_en,
  input  logic [$clog2(ROWS)-1:0]                  ld_row,
  input  logic [COLS-1:0]                          ld_bits,
  input  logic                                     start,
  output logic                                     busy,
  output logic                                     done,
  output logic                                     repair_ok,
  output logic [$clog2(SPARE_R+1)-1:0]             row_num,
  output logic [SPARE_R*$clog2(ROWS)-1:0]          row_list,
  output logic [$clog2(SPARE_C+1)-1:0]             col_num,
  output logic [SPARE_C*$clog2(COLS)-1:0]          col_list,
  output logic [(ROWS-SPARE_R)*$clog2(ROWS)-1:0]   row_map,
  output logic [(COLS-SPARE_C)*$clog2(COLS)-1:0]   col_map
);
  localparam int RW   = $clog2(ROWS);
  localparam int CLW  = $clog2(COLS);
  localparam int NW   = $clog2((ROWS > COLS ? ROWS : COLS) + 1);
  localparam int SRW  = $clog2(SPARE_R + 1);
  localparam int SCW  = $clog2(SPARE_C + 1);
  localparam int LR   = ROWS - SPARE_R;
  localparam int LC   = COLS - SPARE_C;

  alloc_state_e     state;
  logic [COLS-1:0]  bm   [ROWS];
  logic [NW-1:0]    rcnt [ROWS];
  logic [NW-1:0]    ccnt [COLS];
  logic [RW-1:0]    scan;
  logic [ROWS-1:0]  rex;
  logic [COLS-1:0]  cex;
  logic [RW-1:0]    rlst [SPARE_R];
  logic [CLW-1:0]   clst [SPARE_C];
  logic [SRW-1:0]   rn;
  logic [SCW-1:0]   cn;
  logic             ok_q;
  logic [LR*RW-1:0]  rmap_q;
  logic [LC*CLW-1:0] cmap_q;

  logic [ROWS*NW-1:0] rcnt_f;
  logic [COLS*NW-1:0] ccnt_f;
  logic [NW-1:0]      rmax, cmax;
  logic [RW-1:0]      rmax_i;
  logic [CLW-1:0]     cmax_i;
  logic [LR*RW-1:0]   rmap_w;
  logic [LC*CLW-1:0]  cmap_w;
  logic               rows_left, cols_left, take_row, take_col;

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_rflat
      assign rcnt_f[r*NW +: NW] = rcnt[r];
    end
    for (genvar c = 0; c < COLS; c++) begin : g_cflat
      assign ccnt_f[c*NW +: NW] = ccnt[c];
    end
    for (genvar j = 0; j < SPARE_R; j++) begin : g_rlist
      assign row_list[j*RW +: RW] = rlst[j];
    end
    for (genvar j = 0; j < SPARE_C; j++) begin : g_clist
      assign col_list[j*CLW +: CLW] = clst[j];
    end
  endgenerate

  line_peak #(.N(ROWS), .W(NW), .IW(RW)) u_row_peak (
    .cnt_flat(rcnt_f), .peak(rmax), .peak_idx(rmax_i));
  line_peak #(.N(COLS), .W(NW), .IW(CLW)) u_col_peak (
    .cnt_flat(ccnt_f), .peak(cmax), .peak_idx(cmax_i));
  line_remap #(.N(ROWS), .L(LR), .IW(RW)) u_row_remap (
    .excl(rex), .map_flat(rmap_w));
  line_remap #(.N(COLS), .L(LC), .IW(CLW)) u_col_remap (
    .excl(cex), .map_flat(cmap_w));

  assign rows_left = (rn < SRW'(SPARE_R));
  assign cols_left = (cn < SCW'(SPARE_C));

  always_comb begin
    take_row = 1'b0;
    take_col = 1'b0;
    if (rmax >= cmax && rmax != '0 && rows_left)
      take_row = 1'b1;
    else if (cmax != '0 && cols_left)
      take_col = 1'b1;
    else if (rmax != '0 && rows_left)
      take_row = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      scan   <= '0;
      rex    <= '0;
      cex    <= '0;
      rn     <= '0;
      cn     <= '0;
      ok_q   <= 1'b0;
      rmap_q <= '0;
      cmap_q <= '0;
      for (int r = 0; r < ROWS; r++) begin
        bm[r]   <= '0;
        rcnt[r] <= '0;
      end
      for (int c = 0; c < COLS; c++) ccnt[c] <= '0;
      for (int j = 0; j < SPARE_R; j++) rlst[j] <= '0;
      for (int j = 0; j < SPARE_C; j++) clst[j] <= '0;
    end else begin
      case (state)
        ST_COUNT: begin
          rcnt[scan] <= NW'($countones(bm[scan]));
          for (int c = 0; c < COLS; c++)
            ccnt[c] <= ccnt[c] + NW'(bm[scan][c]);
          scan <= scan + 1'b1;
          if (scan == RW'(ROWS - 1)) state <= ST_SELECT;
        end
        ST_SELECT: begin
          if (take_row) begin
            for (int c = 0; c < COLS; c++)
              if (bm[rmax_i][c]) ccnt[c] <= ccnt[c] - 1'b1;
            bm[rmax_i]   <= '0;
            rcnt[rmax_i] <= '0;
            rex[rmax_i]  <= 1'b1;
            rlst[rn]     <= rmax_i;
            rn           <= rn + 1'b1;
          end else if (take_col) begin
            for (int r = 0; r < ROWS; r++) begin
              if (bm[r][cmax_i]) rcnt[r] <= rcnt[r] - 1'b1;
              bm[r][cmax_i] <= 1'b0;
            end
            ccnt[cmax_i] <= '0;
            cex[cmax_i]  <= 1'b1;
            clst[cn]     <= cmax_i;
            cn           <= cn + 1'b1;
          end else begin
            ok_q   <= (rmax == '0) && (cmax == '0);
            rmap_q <= rmap_w;
            cmap_q <= cmap_w;
            state  <= ST_DONE;
          end
        end
        default: begin
          if (ld_en) bm[ld_row] <= ld_bits;
          if (start) begin
            state <= ST_COUNT;
            scan  <= '0;
            rex   <= '0;
            cex   <= '0;
            rn    <= '0;
            cn    <= '0;
            ok_q  <= 1'b0;
            for (int r = 0; r < ROWS; r++) rcnt[r] <= '0;
            for (int c = 0; c < COLS; c++) ccnt[c] <= '0;
            for (int j = 0; j < SPARE_R; j++) rlst[j] <= '0;
            for (int j = 0; j < SPARE_C; j++) clst[j] <= '0;
          end
        end
      endcase
    end
  end

  assign busy      = (state == ST_COUNT) || (state == ST_SELECT);
  assign done      = (state == ST_DONE);
  assign repair_ok = ok_q;
  assign row_num   = rn;
  assign col_num   = cn;
  assign row_map   = rmap_q;
  assign col_map   = cmap_q;
endmodule

// File: rtl/spare_line_alloc_chk.sv
module spare_line_alloc_chk #(
  parameter int SPARE_R = 2,
  parameter int SPARE_C = 2,
  parameter int RLW     = 6,
  parameter int CLW     = 6,
  parameter int SRW     = 2,
  parameter int SCW     = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           repair_ok,
  input logic [SRW-1:0] row_num,
  input logic [SCW-1:0] col_num,
  input logic [RLW-1:0] row_list,
  input logic [CLW-1:0] col_list
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!busy && !done && !repair_ok && row_num == '0 && col_num == '0)); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R3
  AST_SPARE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (row_num <= SRW'(SPARE_R)) && (col_num <= SCW'(SPARE_C))); // R6
  AST_OK_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    repair_ok |-> done); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(row_list) && $stable(col_list)
                          && $stable(repair_ok))); // R11
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R3
endmodule

bind spare_line_alloc spare_line_alloc_chk #(
  .SPARE_R(SPARE_R), .SPARE_C(SPARE_C),
  .RLW(SPARE_R*$clog2(ROWS)), .CLW(SPARE_C*$clog2(COLS)),
  .SRW($clog2(SPARE_R+1)), .SCW($clog2(SPARE_C+1))
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .repair_ok(repair_ok), .row_num(row_num), .col_num(col_num),
  .row_list(row_list), .col_list(col_list)
);

// File: tb/spare_line_alloc_tb.sv
`timescale 1ns/1ps
module spare_line_alloc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_row = '0;
  logic [7:0]  ld_bits = '0;
  logic        start = 1'b0;
  logic        busy, done, repair_ok;
  logic [1:0]  row_num, col_num;
  logic [5:0]  row_list, col_list;
  logic [17:0] row_map, col_map;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  spare_line_alloc u_dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_row(ld_row), .ld_bits(ld_bits),
    .start(start), .busy(busy), .done(done), .repair_ok(repair_ok),
    .row_num(row_num), .row_list(row_list), .col_num(col_num),
    .col_list(col_list), .row_map(row_map), .col_map(col_map));

  // {bitmap(bit r*8+c), rows used, row0, row1, cols used, col0, col1, ok}
  localparam logic [80:0] VEC [7] = '{
    {64'h0000_0000_0000_0000, 2'd0, 3'd0, 3'd0, 2'd0, 3'd0, 3'd0, 1'b1},
    {64'h0000_0000_2000_0000, 2'd1, 3'd3, 3'd0, 2'd0, 3'd0, 3'd0, 1'b1},
    {64'h0002_0000_00FF_0000, 2'd2, 3'd2, 3'd6, 2'd0, 3'd0, 3'd0, 1'b1},
    {64'h1010_1010_1010_1110, 2'd1, 3'd1, 3'd0, 2'd1, 3'd4, 3'd0, 1'b1},
    {64'h0000_3000_0C00_0003, 2'd2, 3'd0, 3'd3, 2'd2, 3'd4, 3'd5, 1'b1},
    {64'h0000_0010_0804_0201, 2'd2, 3'd0, 3'd1, 2'd2, 3'd2, 3'd3, 1'b0},
    {64'h0700_0000_0001_0100, 2'd1, 3'd7, 3'd0, 2'd1, 3'd0, 3'd0, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] surv(input logic [7:0] mask);
    logic [17:0] m;
    int k;
    m = '0;
    k = 0;
    for (int p = 0; p < 8; p++)
      if (!mask[p] && k < 6) begin
        m[k*3 +: 3] = 3'(p);
        k++;
      end
    return m;
  endfunction

  task automatic load_map(input logic [63:0] bmp);
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_row = 3'(r); ld_bits = bmp[r*8 +: 8];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // pulses start; returns edges from the start edge until done
  task automatic run(output int edges);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    while (!done && edges < 100) begin
      @(posedge clk); @(negedge clk);
      edges++;
    end
  endtask

  task automatic report;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int e;
    repeat (3) @(negedge clk);
    chk("R1 busy/done/ok after reset", {busy, done, repair_ok}, 0);
    chk("R1 list counts after reset", {row_num, col_num}, 0);
    rst = 1'b0;

    foreach (VEC[i]) begin
      logic [80:0] v;
      logic [1:0]  rn, cn;
      logic [7:0]  rm, cm;
      v  = VEC[i];
      rn = v[16:15];
      cn = v[8:7];
      rm = '0; cm = '0;
      if (rn > 0) rm[v[14:12]] = 1'b1;
      if (rn > 1) rm[v[11:9]]  = 1'b1;
      if (cn > 0) cm[v[6:4]]   = 1'b1;
      if (cn > 1) cm[v[3:1]]   = 1'b1;
      load_map(v[80:17]);
      run(e);
      chk("R3 edges to done", 64'(e), 64'(8 + rn + cn + 1));
      chk("R4/R5/R6 row count and list", {rn == 0 ? 6'd0 : row_list, row_num},
          {rn == 0 ? 6'd0 : (rn == 1 ? {3'd0, v[14:12]} : {v[11:9], v[14:12]}), rn});
      chk("R7/R8 col count and list", {col_list, col_num},
          {(cn == 0 ? 6'd0 : (cn == 1 ? {3'd0, v[6:4]} : {v[3:1], v[6:4]})), cn});
      chk("R9 repair_ok", 64'(repair_ok), 64'(v[0]));
      chk("R10 row_map", 64'(row_map), 64'(surv(rm)));
      chk("R10 col_map", 64'(col_map), 64'(surv(cm)));
    end

    // R11: results hold while start stays low
    repeat (3) @(negedge clk);
    chk("R11 hold done/lists", {done, row_list, col_list, row_num, col_num},
        {1'b1, 6'b000_111, 6'd0, 2'd1, 2'd1});

    // R2: load during busy is ignored
    load_map(64'h0000_0000_2000_0000);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R3 busy after start", 64'(busy), 1);
    ld_en = 1'b1; ld_row = 3'd6; ld_bits = 8'hFF;
    @(negedge clk);
    ld_en = 1'b0;
    while (!done) @(negedge clk);
    chk("R2 run with ignored load", {row_num, row_list, repair_ok}, {2'd1, 6'd3, 1'b1});
    run(e);
    chk("R2 residual map clean (no stray row 6)", {row_num, col_num, repair_ok}, {2'd0, 2'd0, 1'b1});
    chk("R7 empty run edges", 64'(e), 64'(9));

    // R1: reset mid-run
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset clears busy/done", {busy, done, repair_ok, row_num, col_num}, 0);
    report();
  end
endmodule